// File: doc/BRIEF.md
# Reference PLL Power-On Sequencer

This block brings up the shared reference PLL that clocks the serial PHYs, and it must finish before the SATA PHY is touched. It keeps two control words: a clock-gating word and a PLL control word. A start pulse loads both words from seed inputs. The block then edits them one step at a time, each step a read-modify-write of the held value. The steps are: ungate the SATA clock, take the PLL out of power-down, wait a bounded time for lock, switch the PLL on with its bypass removed, and finally turn on the 100 MHz output.

The lock indication comes from another clock domain and is resynchronised before the block uses it. If lock does not arrive within the poll window, the sequence stops with an error. In that case the PLL word is left exactly as it was after power-up. The done and error flags stay set until the next start, so a slow controller can collect the result at any time.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset the gate word is 0x00000000. The PLL word is 0x00011000, which has power-down (bit 12) and bypass (bit 16) set. The busy, done and error outputs are low.
- R2: A start pulse while idle loads both seeds into the held words, with bit 31 of the PLL seed dropped, and clears done and error. Busy is high from the next cycle until done or error is set.
- R3: One cycle after the load, the 2-bit clock gate field (bits 5:4 of the gate word) becomes 0b11. The other gate bits are not changed.
- R4: One cycle after the gate step, power-down (bit 12) is cleared. This happens before the lock wait begins and is the only change in that step.
- R5: The asynchronous lock input passes through a two-flop synchronizer. Bit 31 of the PLL output always shows the synchronized lock value.
- R6: The lock wait samples the synchronized lock on up to POLL_LIMIT cycles (default 100000). A lock seen on the final sample still counts as success.
- R7: If no lock is seen in the window, error is set POLL_LIMIT+2 cycles after the start edge. No further PLL bit is changed.
- R8: In the cycle after lock is seen, enable (bit 13) is set and bypass (bit 16) is cleared in one update.
- R9: The 100 MHz output enable (bit 20) is set exactly one cycle after the R8 update. Done is set in that same cycle.
- R10: All bits other than those named above keep their seeded values to the end of the sequence.
- R11: A start pulse while busy is ignored. Neither the seeds nor the progress of the running sequence are affected.
- R12: Done and error are never high together, and each stays set until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up sequence (used only when idle) |
| lock_async_i | input | 1 | PLL lock indication, asynchronous |
| gate_seed_i | input | 32 | Value loaded into the gate word on start |
| pll_seed_i | input | 32 | Value loaded into the PLL word on start |
| gate_o | output | 32 | Held clock-gating word |
| pll_o | output | 32 | Held PLL control word; bit 31 is the synchronized lock |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky: sequence completed |
| err_o | output | 1 | Sticky: lock wait timed out |

## Verification
The hardest case is the edge of the lock window, where lock appears through the synchronizer on the very last poll. One cycle later it must turn into a timeout instead. The bench uses a short poll window and raises the asynchronous lock at a counted number of cycles after start. Cases sit just inside and just outside that boundary, allowing for the two synchronizer cycles. Ordering is checked by noting the cycle in which each control bit changes and comparing it with the cycle worked out from the step sequence.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int WORD_W     = 32;
  localparam int GATE_LSB   = 4;
  localparam int GATE_W     = 2;
  localparam int LOCK_BIT   = 31;
  localparam int OUT100_BIT = 20;
  localparam int BYPASS_BIT = 16;
  localparam int ENABLE_BIT = 13;
  localparam int PWRDN_BIT  = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_GATE, S_PWRUP, S_WAIT, S_RUN, S_OUT
  } seq_state_e;

  function automatic logic [WORD_W-1:0] bit_mask(input int pos);
    return WORD_W'(1) << pos;
  endfunction

  function automatic logic [WORD_W-1:0] f_seed_pll(input logic [WORD_W-1:0] w);
    return w & ~bit_mask(LOCK_BIT);
  endfunction

  function automatic logic [WORD_W-1:0] f_ungate(input logic [WORD_W-1:0] w);
    return w | (WORD_W'((1 << GATE_W) - 1) << GATE_LSB);
  endfunction

  function automatic logic [WORD_W-1:0] f_power_up(input logic [WORD_W-1:0] w);
    return w & ~bit_mask(PWRDN_BIT);
  endfunction

  function automatic logic [WORD_W-1:0] f_run(input logic [WORD_W-1:0] w);
    return (w | bit_mask(ENABLE_BIT)) & ~bit_mask(BYPASS_BIT);
  endfunction

  function automatic logic [WORD_W-1:0] f_out_on(input logic [WORD_W-1:0] w);
    return w | bit_mask(OUT100_BIT);
  endfunction
endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr[i] <= 1'b0;
      else if (i == 0) sr[i] <= d_i;
      else             sr[i] <= sr[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr_i)             cnt <= '0;
    else if (en_i && !last_o)   cnt <= cnt + 1'b1;
  end

  assign last_o = (cnt == LAST_VAL);

  // R6: the poll count never runs past the window
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_VAL);
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs import pll_seq_pkg::*; #(
  parameter logic [WORD_W-1:0] RST_GATE = '0,
  parameter logic [WORD_W-1:0] RST_PLL  = 32'h0001_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] gate_seed_i,
  input  logic [WORD_W-1:0] pll_seed_i,
  input  logic              do_gate_i,
  input  logic              do_pwrup_i,
  input  logic              do_run_i,
  input  logic              do_out_i,
  output logic [WORD_W-1:0] gate_q_o,
  output logic [WORD_W-1:0] pll_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q_o <= RST_GATE;
    end else if (load_i) begin
      gate_q_o <= gate_seed_i;
    end else if (do_gate_i) begin
      gate_q_o <= f_ungate(gate_q_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q_o <= f_seed_pll(RST_PLL);
    end else if (load_i) begin
      pll_q_o <= f_seed_pll(pll_seed_i);
    end else if (do_pwrup_i) begin
      pll_q_o <= f_power_up(pll_q_o);
    end else if (do_run_i) begin
      pll_q_o <= f_run(pll_q_o);
    end else if (do_out_i) begin
      pll_q_o <= f_out_on(pll_q_o);
    end
  end

  // R10: the gate word is untouched outside load and the gate step
  a_r10_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !do_gate_i) |=> $stable(gate_q_o));
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq import pll_seq_pkg::*; #(
  parameter int                POLL_LIMIT  = 100000,
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] RST_GATE    = '0,
  parameter logic [WORD_W-1:0] RST_PLL     = 32'h0001_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        lock_async_i,
  input  logic [31:0] gate_seed_i,
  input  logic [31:0] pll_seed_i,
  output logic [31:0] gate_o,
  output logic [31:0] pll_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  seq_state_e state, state_nx;
  logic lock_s, tmr_last;
  logic [WORD_W-1:0] pll_q;

  // named internal events
  logic load_evt, step_gate, step_pwrup, in_wait, wait_hit, wait_expired;
  logic step_run, step_out;

  assign load_evt     = (state == S_IDLE) && start_i;
  assign step_gate    = (state == S_GATE);
  assign step_pwrup   = (state == S_PWRUP);
  assign in_wait      = (state == S_WAIT);
  assign wait_hit     = in_wait && lock_s;
  assign wait_expired = in_wait && !lock_s && tmr_last;
  assign step_run     = (state == S_RUN);
  assign step_out     = (state == S_OUT);

  pll_lock_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(lock_async_i), .q_o(lock_s));

  pll_poll_timer #(.LIMIT(POLL_LIMIT)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(load_evt),
    .en_i(in_wait && !lock_s), .last_o(tmr_last));

  pll_ctrl_regs #(.RST_GATE(RST_GATE), .RST_PLL(RST_PLL)) i_regs (
    .clk(clk), .rst_n(rst_n), .load_i(load_evt),
    .gate_seed_i(gate_seed_i), .pll_seed_i(pll_seed_i),
    .do_gate_i(step_gate), .do_pwrup_i(step_pwrup),
    .do_run_i(step_run), .do_out_i(step_out),
    .gate_q_o(gate_o), .pll_q_o(pll_q));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:  if (load_evt) state_nx = S_GATE;
      S_GATE:  state_nx = S_PWRUP;
      S_PWRUP: state_nx = S_WAIT;
      S_WAIT:  if (wait_hit) state_nx = S_RUN;
               else if (wait_expired) state_nx = S_IDLE;
      S_RUN:   state_nx = S_OUT;
      S_OUT:   state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      state <= state_nx;
      if (load_evt) begin
        done_o <= 1'b0;
        err_o  <= 1'b0;
      end else if (step_out) begin
        done_o <= 1'b1;
      end else if (wait_expired) begin
        err_o  <= 1'b1;
      end
    end
  end

  assign busy_o = (state != S_IDLE);
  assign pll_o  = pll_q | (WORD_W'(lock_s) << LOCK_BIT);

  // R3: gate field is open by the time power-up runs
  a_r3_gate_before_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
    step_pwrup |-> (gate_o[GATE_LSB +: GATE_W] == '1));

  // R4: power-down is already clear throughout the lock wait
  a_r4_pd_clear_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> !pll_o[PWRDN_BIT]);

  // R7: timeout freezes the PLL word and raises error
  a_r7_timeout_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired |=> (err_o && !busy_o && $stable(pll_o[LOCK_BIT-1:0])));

  // R8: enable and bypass removal land together
  a_r8_run_update: assert property (@(posedge clk) disable iff (!rst_n)
    step_run |=> (pll_o[ENABLE_BIT] && !pll_o[BYPASS_BIT] && busy_o));

  // R9: output enable follows an already-enabled PLL, with done
  a_r9_out_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |=> (done_o && pll_o[OUT100_BIT] && $past(pll_o[ENABLE_BIT])));

  // R12: done and error exclusive
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R11: a start while busy does not restart the sequence
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && start_i && !lock_s && !tmr_last) |=> in_wait);
endmodule

// File: tb/test_pll_bringup_seq.sv
module test_pll_bringup_seq;
  localparam int LIM = 20;
  localparam int NV  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        lock_raw = 1'b0;
  logic [31:0] gate_seed = '0;
  logic [31:0] pll_seed = '0;
  logic [31:0] gate_o, pll_o;
  logic        busy_o, done_o, err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pll_bringup_seq #(.POLL_LIMIT(LIM)) i_pll_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .lock_async_i(lock_raw),
    .gate_seed_i(gate_seed), .pll_seed_i(pll_seed),
    .gate_o(gate_o), .pll_o(pll_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  // stimulus table: gate seed, pll seed, lock delay (-1 = never)
  localparam logic [31:0] VG [NV] = '{32'h0000_0000, 32'hA5A5_A5A5, 32'hFFFF_FFCF,
                                     32'h1234_5678, 32'h0000_0000, 32'h0000_0010};
  localparam logic [31:0] VP [NV] = '{32'h0001_1000, 32'h8003_1F0F, 32'h7FEF_DFFF,
                                     32'h0001_1000, 32'h0000_0000, 32'h0001_1000};
  localparam int          VD [NV] = '{0, 5, LIM, LIM+1, 10, -1};

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_gate(input logic [31:0] g);
    logic [31:0] r = g;
    r[5] = 1'b1; r[4] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_pll(input logic [31:0] p, input bit ok);
    logic [31:0] r = p;
    r[31] = 1'b0;
    r[12] = 1'b0;
    if (ok) begin r[13] = 1'b1; r[16] = 1'b0; r[20] = 1'b1; end
    return r;
  endfunction

  task automatic run_seq(input logic [31:0] g, input logic [31:0] p,
                         input int d, input bit mid);
    int kend = 0, kgate = 0, kpd = 0, ken = 0, kout = 0;
    bit ok;
    int w;
    logic [31:0] prevg, prevp;
    ok = (d >= 0) && (d <= LIM);
    w  = (d + 2 > 3) ? d + 2 : 3;
    lock_raw = 1'b0;
    repeat (4) @(negedge clk);
    gate_seed = g; pll_seed = p; start = 1'b1;
    if (d == 0) lock_raw = 1'b1;
    prevg = '0; prevp = '0;
    for (int k = 1; k <= LIM + 40; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", {31'd0, busy_o}, 32'd1);
        check(done_o === 1'b0 && err_o === 1'b0, "R12 flags cleared by start",
              {30'd0, done_o, err_o}, 32'd0);
        check(gate_o === g, "R2 gate seed loaded", gate_o, g);
      end else begin
        if (gate_o[5:4] == 2'b11 && prevg[5:4] != 2'b11 && kgate == 0) kgate = k;
        if (!pll_o[12] && prevp[12] && kpd == 0) kpd = k;
        if (pll_o[13] && !prevp[13] && ken == 0) begin
          ken = k;
          check(pll_o[16] === 1'b0, "R8 bypass cleared with enable",
                {31'd0, pll_o[16]}, 32'd0);
        end
        if (pll_o[20] && !prevp[20] && kout == 0) kout = k;
      end
      prevg = gate_o; prevp = pll_o;
      if (k == d) lock_raw = 1'b1;
      if (mid && k == 5) begin start = 1'b1; gate_seed = ~g; pll_seed = ~p; end
      if (mid && k == 6) start = 1'b0;
      if (done_o || err_o) begin kend = k; break; end
    end
    if (g[5:4] != 2'b11)
      check(kgate == 2, "R3 gate step cycle", kgate, 2);
    if (p[12])
      check(kpd == 3, "R4 power-down cleared before wait", kpd, 3);
    if (ok) begin
      check(kend == w + 3, "R6 done cycle within poll window", kend, w + 3);
      check(ken == w + 2, "R8 enable step cycle", ken, w + 2);
      check(kout == ken + 1, "R9 output enable one cycle after enable", kout, ken + 1);
      check(done_o === 1'b1 && err_o === 1'b0, "R9 done set", {30'd0, done_o, err_o}, 32'd2);
    end else begin
      check(kend == LIM + 3, "R7 timeout cycle", kend, LIM + 3);
      check(ken == 0 && kout == 0, "R7 nothing enabled after timeout", ken + kout, 0);
      check(err_o === 1'b1 && done_o === 1'b0, "R7 error set", {30'd0, done_o, err_o}, 32'd1);
    end
    check(gate_o === exp_gate(g), "R10 final gate word", gate_o, exp_gate(g));
    check(pll_o[30:0] === exp_pll(p, ok)[30:0], "R10 final pll word",
          pll_o, exp_pll(p, ok));
    check(pll_o[31] === ((d >= 0) && (kend >= d + 2)), "R5 synced lock on bit 31",
          {31'd0, pll_o[31]}, {31'd0, (d >= 0) && (kend >= d + 2)});
    @(negedge clk);
    check(busy_o === 1'b0, "R2 idle after finish", {31'd0, busy_o}, 32'd0);
    repeat (8) @(negedge clk);
    check(done_o === ok && err_o === !ok, "R12 flags sticky",
          {30'd0, done_o, err_o}, {30'd0, ok, !ok});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(gate_o === 32'h0, "R1 reset gate word", gate_o, 32'h0);
    check(pll_o === 32'h0001_1000, "R1 reset pll word", pll_o, 32'h0001_1000);
    check({busy_o, done_o, err_o} === 3'b000, "R1 reset flags",
          {29'd0, busy_o, done_o, err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pll_o === 32'h0001_1000 && !busy_o, "R1 idle after reset release", pll_o, 32'h0001_1000);

    for (int i = 0; i < NV; i++) run_seq(VG[i], VP[i], VD[i], 1'b0);

    // R11: start pulse during the lock wait is ignored
    run_seq(32'h0F00_0000, 32'h0001_1000, 10, 1'b1);
    // R6: lock on the very first wait sample after timeout run
    run_seq(32'h0000_0000, 32'h0041_1000, 1, 1'b0);
    // R7: boundary one cycle past the window again
    run_seq(32'h0000_0020, 32'h0001_1001, LIM + 1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule